// File: doc/BRIEF.md
# Byte Divider with Packed Result

This block divides a 16-bit dividend by an 8-bit divisor over a fixed run of clock cycles. The dividend arrives as two bytes, the upper byte and the lower byte. The divisor is one byte. A mode input selects unsigned or two's-complement signed division. The block returns one 16-bit word that holds the 8-bit quotient in its low byte and the 8-bit remainder in its high byte.

A request is a one-cycle start pulse, given while the block is idle. The operands and the mode are captured on that edge. The block then computes one quotient bit per clock using restoring division. When it finishes, it raises done for one cycle.

In signed mode, the divider first works on the magnitudes of the operands. It then corrects the signs of the quotient and the remainder. The block raises fault when the divisor is zero or when the quotient does not fit in a byte for the selected mode. A faulting division leaves the result word as it was.

Top module: `byte_divider`

## Requirements
- R1: After reset, busy, done and fault are 0 and result is 0.
- R2: The dividend is {dvd_hi, dvd_lo}, with dvd_hi as bits 15:8. In unsigned mode (signed_mode=0), a successful division writes the quotient to result[7:0] and the remainder to result[15:8], and the remainder is smaller than the divisor.
- R3: A start is accepted on a rising edge where start=1 and busy=0. From that edge, busy reads 1 for exactly 8 cycles. In the cycle where busy falls back to 0, done is 1 for that single cycle.
- R4: In signed mode (signed_mode=1, two's-complement operands), the quotient is truncated toward zero.
- R5: In signed mode, a nonzero remainder has the sign of the dividend, and |remainder| < |divisor|.
- R6: A zero divisor sets fault together with done and leaves result unchanged.
- R7: In unsigned mode, a quotient above 255 sets fault together with done and leaves result unchanged.
- R8: In signed mode, a quotient outside -128..127 sets fault together with done and leaves result unchanged. A quotient of exactly -128 is valid.
- R9: A start pulse while busy=1 is ignored. Operand changes while busy=1 are also ignored. The running division completes on its original schedule with its original operands.
- R10: fault keeps its value until the next accepted start, which clears it. result changes only in a cycle where done=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| signed_mode | input | 1 | 1 selects two's-complement division |
| dvd_hi | input | 8 | Upper byte of the dividend |
| dvd_lo | input | 8 | Lower byte of the dividend |
| divisor | input | 8 | Divisor byte |
| busy | output | 1 | High while a division runs |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Zero divisor or quotient out of range |
| result | output | 16 | Remainder in bits 15:8, quotient in bits 7:0 |

## Verification
The assertions check the following on every cycle:
- done is a single-cycle pulse, and busy is low while done is high.
- An idle start always raises busy.
- result moves only when done is high, and never on a fault.
- An unsigned result always has a remainder below the captured divisor.

Only the bench's scenarios can show the rest:
- the arithmetic values of the quotient and the remainder;
- the sign rules and the edges of the signed range;
- the exact length of the busy window;
- the fact that a start or an operand change in mid-run has no effect.

// File: rtl/byte_divider.sv
module byte_divider #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [W-1:0]   dvd_hi,
  input  logic [W-1:0]   dvd_lo,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic           fault,
  output logic [2*W-1:0] result
);
  localparam int CNTW = $clog2(W);
  localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);
  localparam logic [W-1:0] QLIM = W'(1) << (W - 1);

  logic [2*W-1:0] dvd_in, dvd_mag;
  logic [W-1:0]   dvs_mag;
  logic           dvd_neg, dvs_neg, pre_bad;

  assign dvd_in  = {dvd_hi, dvd_lo};
  assign dvd_neg = signed_mode & dvd_in[2*W-1];
  assign dvs_neg = signed_mode & divisor[W-1];
  assign dvd_mag = dvd_neg ? -dvd_in : dvd_in;
  assign dvs_mag = dvs_neg ? -divisor : divisor;
  assign pre_bad = (dvs_mag == '0) | (dvd_mag[2*W-1:W] >= dvs_mag);

  logic [W-1:0]    rem, quo, dvs;
  logic [CNTW-1:0] cnt;
  logic            smode, neg_q, neg_r, bad;

  logic [W:0]   trial, diff;
  logic         take;
  logic [W-1:0] rem_nx, quo_nx, q_fin, r_fin;
  logic         range_bad, fail;

  assign trial  = {rem, quo[W-1]};
  assign diff   = trial - {1'b0, dvs};
  assign take   = trial >= {1'b0, dvs};
  assign rem_nx = take ? diff[W-1:0] : trial[W-1:0];
  assign quo_nx = {quo[W-2:0], take};

  assign q_fin     = neg_q ? -quo_nx : quo_nx;
  assign r_fin     = neg_r ? -rem_nx : rem_nx;
  assign range_bad = smode & (neg_q ? (quo_nx > QLIM) : quo_nx[W-1]);
  assign fail      = bad | range_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      fault  <= 1'b0;
      result <= '0;
      rem    <= '0;
      quo    <= '0;
      dvs    <= '0;
      cnt    <= '0;
      smode  <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      bad    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        fault <= 1'b0;
        cnt   <= '0;
        rem   <= dvd_mag[2*W-1:W];
        quo   <= dvd_mag[W-1:0];
        dvs   <= dvs_mag;
        smode <= signed_mode;
        neg_q <= dvd_neg ^ dvs_neg;
        neg_r <= dvd_neg;
        bad   <= pre_bad;
      end else if (busy) begin
        rem <= rem_nx;
        quo <= quo_nx;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          fault <= fail;
          if (!fail) result <= {r_fin, q_fin};
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R3
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R3
  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result)); // R10
  AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (done && fault) |-> $stable(result)); // R6
  AST_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n) (done && !fault && !smode) |-> (result[2*W-1:W] < dvs)); // R2
endmodule

// File: tb/test_byte_divider.sv
module test_byte_divider;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, signed_mode = 1'b0;
  logic [7:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic busy, done, fault;
  logic [15:0] result;
  logic [15:0] exp_res = '0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_divider i_byte_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .busy(busy), .done(done), .fault(fault), .result(result));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model(input bit sm, input logic [15:0] dd, input logic [7:0] dv, output bit f);
    int a, b, q, r;
    a = sm ? int'($signed(dd)) : int'(dd);
    b = sm ? int'($signed(dv)) : int'(dv);
    if (b == 0) begin
      f = 1'b1;
      return;
    end
    q = a / b;
    r = a % b;
    f = sm ? (q < -128 || q > 127) : (q > 255);
    if (!f) exp_res = {r[7:0], q[7:0]};
  endtask

  task automatic run_div(input bit sm, input logic [15:0] dd, input logic [7:0] dv, input string tag,
                         input bit disturb = 1'b0);
    bit f, timing_ok;
    model(sm, dd, dv, f);
    @(negedge clk);
    signed_mode = sm; dvd_hi = dd[15:8]; dvd_lo = dd[7:0]; divisor = dv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(fault === 1'b0, "R10 fault cleared on start", 32'(fault), 0);
    timing_ok = (busy === 1'b1);
    for (int i = 1; i < 8; i++) begin
      if (disturb && i == 3) begin
        start = 1'b1; dvd_hi = ~dvd_hi; dvd_lo = 8'h5A; divisor = 8'h03; signed_mode = ~signed_mode;
      end
      @(negedge clk);
      start = 1'b0;
      if (busy !== 1'b1 || done !== 1'b0) timing_ok = 1'b0;
    end
    @(negedge clk);
    check(timing_ok && busy === 1'b0 && done === 1'b1, {"R3 ", tag}, {30'd0, busy, done}, 32'b01);
    check(fault === f, {tag, " fault"}, 32'(fault), 32'(f));
    check(result === exp_res, {tag, " result"}, 32'(result), 32'(exp_res));
    @(negedge clk);
    check(done === 1'b0, "R3 done single cycle", 32'(done), 0);
  endtask

  task automatic test_reset();
    check(busy === 0 && done === 0 && fault === 0 && result === 16'h0, "R1 reset",
          {13'd0, busy, done, fault, result}, 0);
  endtask

  task automatic test_unsigned();
    run_div(0, 16'd1000, 8'd7, "R2 1000/7");
    run_div(0, 16'h1234, 8'h40, "R2 1234/40");
    run_div(0, 16'hFEFF, 8'hFF, "R2 max quotient 255");
    run_div(0, 16'h0005, 8'h09, "R2 small dividend");
    run_div(0, 16'hFFFF, 8'hFF, "R7 overflow 257");
    run_div(0, 16'h0100, 8'h01, "R7 overflow 256");
  endtask

  task automatic test_signed();
    run_div(1, 16'hFFF9, 8'h02, "R4 -7/2");
    run_div(1, 16'h0007, 8'hFE, "R5 7/-2");
    run_div(1, 16'hFFF9, 8'hFE, "R5 -7/-2");
    run_div(1, 16'h4000, 8'h80, "R8 quotient -128 valid");
    run_div(1, 16'hFF80, 8'hFF, "R8 -128/-1 overflow");
    run_div(1, 16'hC000, 8'h80, "R8 -16384/-128 overflow");
    run_div(1, 16'h8000, 8'h80, "R8 -32768/-128 overflow");
    run_div(1, 16'h3F80, 8'h7F, "R4 16256/127");
  endtask

  task automatic test_zero();
    run_div(0, 16'h0042, 8'h00, "R6 unsigned zero divisor");
    run_div(1, 16'hFF00, 8'h00, "R6 signed zero divisor");
    repeat (3) @(negedge clk);
    check(fault === 1'b1 && result === exp_res, "R10 fault and result held", {15'd0, fault, result}, {15'd0, 1'b1, exp_res});
  endtask

  task automatic test_ignore();
    run_div(0, 16'h2710, 8'hC8, "R9 start while busy", 1'b1);
    run_div(1, 16'hFC18, 8'h21, "R9 signed start while busy", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_unsigned();
    test_signed();
    test_zero();
    test_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule